// File: doc/BRIEF.md
# Fill-Level Driven QoS Priority Controller

This block sets the read-address and write-address QoS priorities of four high-performance AXI slave ports from the fill levels of their data FIFOs. Each port has one hysteresis tracker on its read-data level and one on its write-data level. A read-data FIFO that drains to its low threshold raises the port's read QoS to a boosted value. The boost lasts until the FIFO refills to its high threshold. The write side mirrors this. A write-data FIFO that fills to its high threshold boosts the write QoS, and the boost lasts until the FIFO drains to its low threshold. The gap between the two thresholds absorbs fill counts that are a few entries off, as happens when they cross clock domains.

A per-port override bit replaces the computed values with two fixed, software-programmed QoS values, one for each channel. The trackers keep following the levels while the override is on, so dropping the override shows the current boost state straight away. Both QoS outputs are registered. They carry the value to present with the port's next address command. The AXI channel logic samples them while its address-valid is high.

Top module: `qos_level_ctrl`

## Requirements
- R1: While reset is low, every `arqos_o` and `awqos_o` field is 0. The first update after reset leaves every port un-boosted: with override off, both fields equal the port's normal QoS.
- R2: A port whose read-data level is at or below its read low threshold gets `arqos_o` equal to its boosted QoS at the next clock edge.
- R3: While the read-data level lies strictly between the read low and high thresholds, the read boost state of the port does not change.
- R4: A boosted port whose read-data level is at or above its read high threshold returns `arqos_o` to its normal QoS at the next clock edge.
- R5: The write boost of a port sets when its write-data level is at or above the write high threshold. It clears when the level is at or below the write low threshold, and it holds in between. `awqos_o` shows boosted or normal QoS accordingly.
- R6: With `fix_en_i` set for a port, `arqos_o` equals `fix_arqos_i` and `awqos_o` equals `fix_awqos_i` from the next clock edge on, whatever the levels.
- R7: Boost tracking continues while the override is on. After `fix_en_i` clears, the next edge shows the boost state the levels imply.
- R8: Each port's outputs depend only on that port's own inputs.
- R9: Outputs change only at a rising clock edge, never between edges when inputs move.
- Port p occupies bits [p*W +: W] of every packed vector, with W = 8 for levels and thresholds, 4 for QoS values and 1 for `fix_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_lvl_i | input | 32 | Read-data FIFO fill level per port |
| wr_lvl_i | input | 32 | Write-data FIFO fill level per port |
| rd_lo_th_i | input | 32 | Read boost start threshold per port |
| rd_hi_th_i | input | 32 | Read boost end threshold per port |
| wr_lo_th_i | input | 32 | Write boost end threshold per port |
| wr_hi_th_i | input | 32 | Write boost start threshold per port |
| norm_qos_i | input | 16 | Normal QoS per port |
| boost_qos_i | input | 16 | Boosted QoS per port |
| fix_en_i | input | 4 | Fixed-QoS override enable per port |
| fix_arqos_i | input | 16 | Fixed read QoS per port |
| fix_awqos_i | input | 16 | Fixed write QoS per port |
| arqos_o | output | 16 | Read-address QoS per port |
| awqos_o | output | 16 | Write-address QoS per port |

## Verification
The bench runs triangle-wave fill levels with a different rate and phase on every port. This passes each threshold from both directions many times. It also sets levels exactly at, one above and one below each threshold. A design with an off-by-one compare would boost one entry late, and one that drops the hysteresis would toggle the boost state inside the band.

Override windows open and close while the levels move. A design that freezes its trackers during override shows a stale boost state when the override drops. Another phase holds one port steady while its neighbours swing, to catch state shared between ports. Inputs also change half a cycle before each edge, which exposes any output that follows its inputs combinationally.

// File: rtl/qlc_pkg.sv
package qlc_pkg;
  localparam int unsigned QLC_PORTS = 4;
  localparam int unsigned QLC_LVL_W = 8;
  localparam int unsigned QLC_QOS_W = 4;
endpackage

// File: rtl/qlc_rst_sync.sv
module qlc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/qlc_hyst.sv
module qlc_hyst #(
  parameter int unsigned LVL_W   = qlc_pkg::QLC_LVL_W,
  parameter bit          RISE_ON = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] lo_i,
  input  logic [LVL_W-1:0] hi_i,
  output logic             flag_d_o,
  output logic             flag_q_o
);
  logic on_c, off_c, flag_d, flag_q;

  always_comb begin
    if (RISE_ON) begin
      on_c  = (lvl_i >= hi_i);
      off_c = (lvl_i <= lo_i);
    end else begin
      on_c  = (lvl_i <= lo_i);
      off_c = (lvl_i >= hi_i);
    end
    flag_d = flag_q ? !off_c : on_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_d_o = flag_d;
  assign flag_q_o = flag_q;

  // R2 (read side) and R5 (write side): entry condition sets the flag
  p_hyst_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && on_c) |=> flag_q);
  // R4 / R5: exit condition clears the flag
  p_hyst_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && off_c) |=> !flag_q);
  // R3: inside the band the state holds
  p_hyst_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i > lo_i && lvl_i < hi_i) |=> $stable(flag_q));
endmodule

// File: rtl/qlc_lane.sv
module qlc_lane #(
  parameter int unsigned LVL_W = qlc_pkg::QLC_LVL_W,
  parameter int unsigned QOS_W = qlc_pkg::QLC_QOS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] rd_lvl_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  input  logic [LVL_W-1:0] rd_lo_i,
  input  logic [LVL_W-1:0] rd_hi_i,
  input  logic [LVL_W-1:0] wr_lo_i,
  input  logic [LVL_W-1:0] wr_hi_i,
  input  logic [QOS_W-1:0] norm_i,
  input  logic [QOS_W-1:0] boost_i,
  input  logic             fix_en_i,
  input  logic [QOS_W-1:0] fix_ar_i,
  input  logic [QOS_W-1:0] fix_aw_i,
  output logic [QOS_W-1:0] arqos_o,
  output logic [QOS_W-1:0] awqos_o
);
  logic rd_boost_d, rd_boost_q, wr_boost_d, wr_boost_q;
  logic [QOS_W-1:0] ar_d, aw_d, ar_q, aw_q;
  logic upd_en;

  qlc_hyst #(.LVL_W(LVL_W), .RISE_ON(1'b0)) u_rd_hyst (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(rd_lvl_i), .lo_i(rd_lo_i),
    .hi_i(rd_hi_i), .flag_d_o(rd_boost_d), .flag_q_o(rd_boost_q));

  qlc_hyst #(.LVL_W(LVL_W), .RISE_ON(1'b1)) u_wr_hyst (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(wr_lvl_i), .lo_i(wr_lo_i),
    .hi_i(wr_hi_i), .flag_d_o(wr_boost_d), .flag_q_o(wr_boost_q));

  always_comb begin
    if (fix_en_i) begin
      ar_d = fix_ar_i;
      aw_d = fix_aw_i;
    end else begin
      ar_d = rd_boost_d ? boost_i : norm_i;
      aw_d = wr_boost_d ? boost_i : norm_i;
    end
    upd_en = (ar_d != ar_q) || (aw_d != aw_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q <= '0;
      aw_q <= '0;
    end else if (upd_en) begin
      ar_q <= ar_d;
      aw_q <= aw_d;
    end
  end

  assign arqos_o = ar_q;
  assign awqos_o = aw_q;

  // R6: override wins on the next edge
  p_fix_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_en_i |=> (arqos_o == $past(fix_ar_i)));
  p_fix_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_en_i |=> (awqos_o == $past(fix_aw_i)));
  // R2 / R4: un-overridden read QoS follows the tracker state
  p_rd_track_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fix_en_i |=> (arqos_o == (rd_boost_q ? $past(boost_i) : $past(norm_i))));
  // R5: un-overridden write QoS follows the tracker state
  p_wr_track_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fix_en_i |=> (awqos_o == (wr_boost_q ? $past(boost_i) : $past(norm_i))));
endmodule

// File: rtl/qos_level_ctrl.sv
module qos_level_ctrl #(
  parameter int unsigned NPORT = qlc_pkg::QLC_PORTS,
  parameter int unsigned LVL_W = qlc_pkg::QLC_LVL_W,
  parameter int unsigned QOS_W = qlc_pkg::QLC_QOS_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NPORT*LVL_W-1:0] rd_lvl_i,
  input  logic [NPORT*LVL_W-1:0] wr_lvl_i,
  input  logic [NPORT*LVL_W-1:0] rd_lo_th_i,
  input  logic [NPORT*LVL_W-1:0] rd_hi_th_i,
  input  logic [NPORT*LVL_W-1:0] wr_lo_th_i,
  input  logic [NPORT*LVL_W-1:0] wr_hi_th_i,
  input  logic [NPORT*QOS_W-1:0] norm_qos_i,
  input  logic [NPORT*QOS_W-1:0] boost_qos_i,
  input  logic [NPORT-1:0]       fix_en_i,
  input  logic [NPORT*QOS_W-1:0] fix_arqos_i,
  input  logic [NPORT*QOS_W-1:0] fix_awqos_i,
  output logic [NPORT*QOS_W-1:0] arqos_o,
  output logic [NPORT*QOS_W-1:0] awqos_o
);
  logic rst_sync_n;

  qlc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_sync_n));

  for (genvar p = 0; p < NPORT; p++) begin : g_lane
    qlc_lane #(.LVL_W(LVL_W), .QOS_W(QOS_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .rd_lvl_i(rd_lvl_i[p*LVL_W +: LVL_W]),
      .wr_lvl_i(wr_lvl_i[p*LVL_W +: LVL_W]),
      .rd_lo_i (rd_lo_th_i[p*LVL_W +: LVL_W]),
      .rd_hi_i (rd_hi_th_i[p*LVL_W +: LVL_W]),
      .wr_lo_i (wr_lo_th_i[p*LVL_W +: LVL_W]),
      .wr_hi_i (wr_hi_th_i[p*LVL_W +: LVL_W]),
      .norm_i  (norm_qos_i[p*QOS_W +: QOS_W]),
      .boost_i (boost_qos_i[p*QOS_W +: QOS_W]),
      .fix_en_i(fix_en_i[p]),
      .fix_ar_i(fix_arqos_i[p*QOS_W +: QOS_W]),
      .fix_aw_i(fix_awqos_i[p*QOS_W +: QOS_W]),
      .arqos_o (arqos_o[p*QOS_W +: QOS_W]),
      .awqos_o (awqos_o[p*QOS_W +: QOS_W]));
  end

  // R1: outputs cleared while the block is held in reset
  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_sync_n |-> (arqos_o == '0 && awqos_o == '0));
endmodule

// File: tb/qos_level_ctrl_bench.sv
`timescale 1ns/1ps
module qos_level_ctrl_bench;
  localparam int NP = 4;
  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [7:0] rd_v [NP], wr_v [NP], rlo [NP], rhi [NP], wlo [NP], whi [NP];
  logic [3:0] nq [NP], bq [NP], far [NP], faw [NP];
  logic       fen [NP];
  logic [NP*8-1:0] rd_p, wr_p, rlo_p, rhi_p, wlo_p, whi_p;
  logic [NP*4-1:0] nq_p, bq_p, far_p, faw_p, ar_o, aw_o;
  logic [NP-1:0]   fen_p;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      rd_p[p*8 +: 8] = rd_v[p];  wr_p[p*8 +: 8] = wr_v[p];
      rlo_p[p*8 +: 8] = rlo[p];  rhi_p[p*8 +: 8] = rhi[p];
      wlo_p[p*8 +: 8] = wlo[p];  whi_p[p*8 +: 8] = whi[p];
      nq_p[p*4 +: 4] = nq[p];    bq_p[p*4 +: 4] = bq[p];
      far_p[p*4 +: 4] = far[p];  faw_p[p*4 +: 4] = faw[p];
      fen_p[p] = fen[p];
    end
  end

  qos_level_ctrl u_qos_level_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rd_lvl_i(rd_p), .wr_lvl_i(wr_p),
    .rd_lo_th_i(rlo_p), .rd_hi_th_i(rhi_p), .wr_lo_th_i(wlo_p),
    .wr_hi_th_i(whi_p), .norm_qos_i(nq_p), .boost_qos_i(bq_p),
    .fix_en_i(fen_p), .fix_arqos_i(far_p), .fix_awqos_i(faw_p),
    .arqos_o(ar_o), .awqos_o(aw_o));

  int tests = 0, fails = 0;
  logic rb [NP], wb [NP], pfix [NP];
  logic [3:0] exp_ar [NP], exp_aw [NP];

  task automatic chk(string tag, int p, string ch, logic [3:0] act, logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s port %0d %s: got %0d expected %0d", tag, p, ch, act, exp);
    end
  endtask

  function automatic logic [7:0] tri_w(int x);
    int m = x % 512;
    return (m < 256) ? m[7:0] : 8'(511 - m);
  endfunction

  // inputs already set; called just after a negedge
  task automatic step(bit r8_port0);
    logic nrb, nwb;
    string tr, tw;
    #1;
    for (int p = 0; p < NP; p++) begin
      chk("R9", p, "arqos", ar_o[p*4 +: 4], exp_ar[p]);
      chk("R9", p, "awqos", aw_o[p*4 +: 4], exp_aw[p]);
    end
    @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      nrb = rb[p] ? !(rd_v[p] >= rhi[p]) : (rd_v[p] <= rlo[p]);
      nwb = wb[p] ? !(wr_v[p] <= wlo[p]) : (wr_v[p] >= whi[p]);
      if (fen[p]) begin tr = "R6"; tw = "R6"; end
      else if (pfix[p]) begin tr = "R7"; tw = "R7"; end
      else begin
        tr = (nrb && !rb[p]) ? "R2" : (!nrb && rb[p]) ? "R4" : "R3";
        tw = "R5";
      end
      if (r8_port0 && p == 0) begin tr = "R8"; tw = "R8"; end
      rb[p] = nrb; wb[p] = nwb; pfix[p] = fen[p];
      exp_ar[p] = fen[p] ? far[p] : (nrb ? bq[p] : nq[p]);
      exp_aw[p] = fen[p] ? faw[p] : (nwb ? bq[p] : nq[p]);
      tests += 0;
      if (p == 0) ;
      // compare after the edge, at the negedge
      tr_s[p] = tr; tw_s[p] = tw;
    end
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      chk(tr_s[p], p, "arqos", ar_o[p*4 +: 4], exp_ar[p]);
      chk(tw_s[p], p, "awqos", aw_o[p*4 +: 4], exp_aw[p]);
    end
  endtask
  string tr_s [NP], tw_s [NP];

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int p = 0; p < NP; p++) begin
      rlo[p] = 8'(40 + 10*p); rhi[p] = 8'(180 - 10*p);
      wlo[p] = 8'(60 + 5*p);  whi[p] = 8'(200 - 5*p);
      nq[p] = 4'(p + 1); bq[p] = 4'(8 + 2*p);
      far[p] = 4'(15 - p); faw[p] = 4'(12 - p);
      fen[p] = 1'b0; rb[p] = 1'b0; wb[p] = 1'b0; pfix[p] = 1'b0;
      rd_v[p] = 8'd120; wr_v[p] = 8'd120;
    end
    repeat (4) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      chk("R1", p, "arqos in reset", ar_o[p*4 +: 4], 4'd0);
      chk("R1", p, "awqos in reset", aw_o[p*4 +: 4], 4'd0);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      chk("R1", p, "arqos after reset", ar_o[p*4 +: 4], nq[p]);
      chk("R1", p, "awqos after reset", aw_o[p*4 +: 4], nq[p]);
      exp_ar[p] = nq[p]; exp_aw[p] = nq[p];
    end
    // directed boundary sequence on port 0 (R2 / R3 / R4 / R5 thresholds exactly)
    rd_v[0] = rlo[0] + 8'd1; step(1'b0);
    rd_v[0] = rlo[0];        step(1'b0);
    rd_v[0] = rhi[0] - 8'd1; step(1'b0);
    rd_v[0] = rhi[0];        step(1'b0);
    wr_v[0] = whi[0] - 8'd1; step(1'b0);
    wr_v[0] = whi[0];        step(1'b0);
    wr_v[0] = wlo[0] + 8'd1; step(1'b0);
    wr_v[0] = wlo[0];        step(1'b0);
    // sweeps with override windows (R6 / R7)
    for (int t = 0; t < 2000; t++) begin
      for (int p = 0; p < NP; p++) begin
        rd_v[p] = tri_w(t*(p+1)*3 + p*77);
        wr_v[p] = tri_w(t*(5-p)*2 + p*31);
      end
      fen[2] = (t >= 600 && t < 900);
      fen[1] = (t >= 1200 && t < 1300);
      fen[3] = (t % 97) < 5;
      step(1'b0);
    end
    for (int p = 0; p < NP; p++) fen[p] = 1'b0;
    // R8: port 0 steady while the others swing
    rd_v[0] = 8'd120; wr_v[0] = 8'd120;
    for (int t = 0; t < 600; t++) begin
      for (int p = 1; p < NP; p++) begin
        rd_v[p] = tri_w(t*7 + p*50);
        wr_v[p] = tri_w(t*5 + p*90);
      end
      fen[3] = (t % 50) < 10;
      step(1'b1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule